// File: doc/BRIEF.md
# Interrupt Status and Halt Controller

This block collects event pulses from a DMA engine and from a SCSI bus engine and holds each one as a latched status bit. It drives an active-low interrupt request pin and a halt request to the instruction sequencer. Software reads a status register to find out which conditions are pending. That read also clears the conditions it reported. The one exception is a live FIFO-empty bit, which a read never clears.

Each source has its own enable mask. A global pin-mask bit can hide the interrupt at the pin while the conditions stay latched. Every DMA condition is fatal and halts the sequencer whether or not it is enabled. A SCSI condition is nonfatal until its enable bit is set. Once enabled, it both drives the pin and halts the sequencer.

Software also has a FIFO-control register. Writing it produces one-cycle strobes that clear or flush the FIFOs after an interrupt has been handled.

The halt logic is a two-state machine. It starts in `ST_RUN`. The transition *fatal seen* moves it to `ST_HALT` when any fatal condition was latched in the previous cycle. The transition *all clear* returns it to `ST_RUN` when no fatal condition was latched in the previous cycle. `halt_req` is high only in `ST_HALT`.

Top module: `irq_halt_ctrl`

Register addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | DMA status | Bits 6:0 hold the latched DMA conditions. Bit 7 is the live FIFO-empty bit. |
| 1 | DMA enable | Bits 6:0 are the enables for the DMA conditions. |
| 2 | SCSI status | Bits 7:0 hold the latched SCSI conditions. |
| 3 | SCSI enable | Bits 7:0 are the enables for the SCSI conditions. |
| 4 | Control | Bit 1 is the pin mask. |
| 5 | FIFO control | Bit 1 clears the SCSI FIFO. Bit 2 clears the DMA FIFO. Bit 3 flushes the DMA FIFO. |

## Requirements
- R1: After reset, `irq_n` is 1, `halt_req` is 0 and all three FIFO strobes are 0. The DMA status register (address 0) reads 0x80 when `dma_fifo_empty` is 1, and the SCSI status register (address 2) reads 0x00.
- R2: A pulse on `dma_evt[i]` sets bit i of the DMA status register at the next clock edge. A read of address 0 returns the latched bits and clears bits 6:0 at the clock edge that ends the read cycle.
- R3: Bit 7 of the DMA status register always equals the live `dma_fifo_empty` input. A read never clears it, and it never affects `irq_n` or `halt_req`.
- R4: A latched DMA bit whose enable bit (address 1, same position) is set drives `irq_n` low in the cycle after the event. Any latched DMA bit is fatal and raises `halt_req`, whether it is enabled or not.
- R5: A latched SCSI bit whose enable bit (address 3, same position) is clear shows only in the status register. It leaves `irq_n` at 1 and `halt_req` at 0.
- R6: A latched SCSI bit whose enable bit is set drives `irq_n` low and raises `halt_req`. This also applies when the enable is written after the bit has latched.
- R7: While control bit 1 (address 4) is 1, `irq_n` stays 1. Pending conditions stay latched, and `halt_req` is not affected.
- R8: Writing control bit 1 to 0 while an enabled condition is pending drives `irq_n` low in the cycle right after the write edge.
- R9: If an event pulse and a clearing read of the same status bit fall in the same cycle, the bit stays set. Bits that were not pulsed in that cycle are cleared.
- R10: Writing 1 to FIFO-control bit 2 (clear DMA FIFO), bit 1 (clear SCSI FIFO) or bit 3 (flush DMA FIFO) raises the matching strobe for exactly the one cycle after the write edge. The bits then self-clear.
- R11: `halt_req` rises one cycle after a fatal condition is first latched (*fatal seen*). It falls one cycle after the last fatal condition is cleared (*all clear*).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe. Clears status registers on read. |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| dma_evt | input | 7 | DMA condition pulses |
| scsi_evt | input | 8 | SCSI condition pulses |
| dma_fifo_empty | input | 1 | Live DMA FIFO empty flag |
| irq_n | output | 1 | Interrupt request pin, active low |
| halt_req | output | 1 | Halt request to the sequencer |
| clr_dma_fifo | output | 1 | One-cycle strobe that clears the DMA FIFO |
| clr_scsi_fifo | output | 1 | One-cycle strobe that clears the SCSI FIFO |
| flush_dma_fifo | output | 1 | One-cycle strobe that flushes the DMA FIFO |

## Verification
A new event pulse and a clearing status read can both land on the same bit in one cycle. This is the collision that decides whether an interrupt is lost. The bench provokes it by raising a SCSI pulse and a DMA pulse in the exact cycle the matching status register is read. It expects the read in that cycle to return the old contents. The following read must show the re-pulsed bit still set and every other bit cleared.

// File: rtl/irq_halt_pkg.sv
`timescale 1ns/1ps
package irq_halt_pkg;
    localparam int unsigned ADR_DMA_STAT  = 0;
    localparam int unsigned ADR_DMA_EN    = 1;
    localparam int unsigned ADR_SCSI_STAT = 2;
    localparam int unsigned ADR_SCSI_EN   = 3;
    localparam int unsigned ADR_CTRL      = 4;
    localparam int unsigned ADR_FIFO_CTRL = 5;

    localparam int unsigned PIN_MASK_BIT  = 1;
    // FIFO control: bit1 clear SCSI, bit2 clear DMA, bit3 flush DMA
    localparam int unsigned FIFO_FIRST_BIT = 1;
    localparam int unsigned FIFO_NUM_STB   = 3;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } halt_state_e;
endpackage

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             rd_clr,
    output logic [WIDTH-1:0] stat
);
    logic [WIDTH-1:0] stat_q;

    // A new event in the clearing cycle survives the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (rd_clr ? '0 : stat_q) | evt;
    end

    assign stat = stat_q;
endmodule

// File: rtl/irq_fifo_strobe.sv
`timescale 1ns/1ps
module irq_fifo_strobe #(
    parameter int unsigned NUM_STB = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [NUM_STB-1:0] wbits,
    output logic [NUM_STB-1:0] strobe
);
    for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
        logic stb_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= wr_hit & wbits[i];
        end
        assign strobe[i] = stb_q;
    end
endmodule

// File: rtl/irq_halt_fsm.sv
`timescale 1ns/1ps
module irq_halt_fsm
    import irq_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fatal,
    output logic halt_req
);
    halt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (fatal)  state_d = ST_HALT;   // fatal seen
            ST_HALT: if (!fatal) state_d = ST_RUN;    // all clear
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HALT: halt_req = 1'b1;
            default: halt_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_halt_ctrl.sv
`timescale 1ns/1ps
module irq_halt_ctrl
    import irq_halt_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SCSI_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [DATA_W-2:0]      dma_evt,
    input  logic [SCSI_W-1:0]      scsi_evt,
    input  logic                   dma_fifo_empty,
    output logic                   irq_n,
    output logic                   halt_req,
    output logic                   clr_dma_fifo,
    output logic                   clr_scsi_fifo,
    output logic                   flush_dma_fifo
);
    localparam int unsigned DMA_W = DATA_W - 1;

    logic [DMA_W-1:0]        dma_stat, dma_en;
    logic [SCSI_W-1:0]       scsi_stat, scsi_en;
    logic                    pin_mask;
    logic [FIFO_NUM_STB-1:0] fifo_stb;
    logic                    rd_dma, rd_scsi, wr_fifo;
    logic                    dma_pend, scsi_pend, fatal;

    assign rd_dma  = reg_rd && (reg_addr == ADDR_W'(ADR_DMA_STAT));
    assign rd_scsi = reg_rd && (reg_addr == ADDR_W'(ADR_SCSI_STAT));
    assign wr_fifo = reg_wr && (reg_addr == ADDR_W'(ADR_FIFO_CTRL));

    irq_status_bank #(.WIDTH(DMA_W)) u_dma_bank (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt), .rd_clr(rd_dma), .stat(dma_stat)
    );

    irq_status_bank #(.WIDTH(SCSI_W)) u_scsi_bank (
        .clk(clk), .rst_n(rst_n), .evt(scsi_evt), .rd_clr(rd_scsi), .stat(scsi_stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_en   <= '0;
            scsi_en  <= '0;
            pin_mask <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADR_DMA_EN))  dma_en   <= reg_wdata[DMA_W-1:0];
            if (reg_addr == ADDR_W'(ADR_SCSI_EN)) scsi_en  <= reg_wdata[SCSI_W-1:0];
            if (reg_addr == ADDR_W'(ADR_CTRL))    pin_mask <= reg_wdata[PIN_MASK_BIT];
        end
    end

    irq_fifo_strobe #(.NUM_STB(FIFO_NUM_STB)) u_fifo_stb (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_fifo),
        .wbits(reg_wdata[FIFO_FIRST_BIT +: FIFO_NUM_STB]), .strobe(fifo_stb)
    );

    assign clr_scsi_fifo  = fifo_stb[0];
    assign clr_dma_fifo   = fifo_stb[1];
    assign flush_dma_fifo = fifo_stb[2];

    // Pin: enabled conditions only. Halt: every DMA bit, enabled SCSI bits.
    assign dma_pend  = |(dma_stat & dma_en);
    assign scsi_pend = |(scsi_stat & scsi_en);
    assign fatal     = (|dma_stat) | scsi_pend;
    assign irq_n     = ~((dma_pend | scsi_pend) & ~pin_mask);

    irq_halt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fatal(fatal), .halt_req(halt_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(ADR_DMA_STAT):  reg_rdata = {dma_fifo_empty, dma_stat};
            ADDR_W'(ADR_DMA_EN):    reg_rdata = {1'b0, dma_en};
            ADDR_W'(ADR_SCSI_STAT): reg_rdata = DATA_W'(scsi_stat);
            ADDR_W'(ADR_SCSI_EN):   reg_rdata = DATA_W'(scsi_en);
            ADDR_W'(ADR_CTRL):      reg_rdata[PIN_MASK_BIT] = pin_mask;
            ADDR_W'(ADR_FIFO_CTRL): reg_rdata[FIFO_FIRST_BIT +: FIFO_NUM_STB] = fifo_stb;
            default:                reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_halt_chk.sv
`timescale 1ns/1ps
module irq_halt_chk #(
    parameter int unsigned DMA_W  = 7,
    parameter int unsigned SCSI_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_mask,
    input logic              irq_n,
    input logic              halt_req,
    input logic [DMA_W-1:0]  dma_stat,
    input logic [SCSI_W-1:0] scsi_stat,
    input logic [SCSI_W-1:0] scsi_en,
    input logic [SCSI_W-1:0] scsi_evt,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2:0]        fifo_wbits,
    input logic              clr_scsi_fifo,
    input logic              clr_dma_fifo,
    input logic              flush_dma_fifo
);
    assert_dma_fatal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|dma_stat)) |-> halt_req);

    assert_enabled_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(scsi_stat & scsi_en)) && !pin_mask) |-> !irq_n);

    assert_mask_holds_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mask |-> irq_n);

    assert_event_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|scsi_evt)) |-> ((scsi_stat & $past(scsi_evt)) == $past(scsi_evt)));

    assert_clr_dma_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dma_fifo |-> $past(reg_wr && (reg_addr == ADDR_W'(5)) && fifo_wbits[1]));

    assert_clr_scsi_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_scsi_fifo |-> $past(reg_wr && (reg_addr == ADDR_W'(5)) && fifo_wbits[0]));

    assert_flush_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dma_fifo |-> $past(reg_wr && (reg_addr == ADDR_W'(5)) && fifo_wbits[2]));
endmodule

bind irq_halt_ctrl irq_halt_chk #(.DMA_W(DATA_W - 1), .SCSI_W(SCSI_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_mask(pin_mask), .irq_n(irq_n), .halt_req(halt_req),
    .dma_stat(dma_stat), .scsi_stat(scsi_stat), .scsi_en(scsi_en), .scsi_evt(scsi_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .fifo_wbits(reg_wdata[3:1]),
    .clr_scsi_fifo(clr_scsi_fifo), .clr_dma_fifo(clr_dma_fifo), .flush_dma_fifo(flush_dma_fifo)
);

// File: tb/irq_halt_ctrl_test.sv
`timescale 1ns/1ps
module irq_halt_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] dma_evt = '0;
    logic [7:0] scsi_evt = '0;
    logic       dma_fifo_empty = 1'b1;
    logic       irq_n, halt_req, clr_dma_fifo, clr_scsi_fifo, flush_dma_fifo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    irq_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_evt(dma_evt), .scsi_evt(scsi_evt),
        .dma_fifo_empty(dma_fifo_empty), .irq_n(irq_n), .halt_req(halt_req),
        .clr_dma_fifo(clr_dma_fifo), .clr_scsi_fifo(clr_scsi_fifo), .flush_dma_fifo(flush_dma_fifo)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    // driver: push the expected read value, the monitor compares it
    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_addr = a; reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic pins(input string tag, input logic irq_exp, input logic halt_exp);
        @(negedge clk);
        check({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, irq_exp});
        check({tag, " halt_req"}, {7'b0, halt_req}, {7'b0, halt_exp});
    endtask

    task automatic strobes(input string tag, input logic [7:0] exp);
        @(negedge clk);
        check({tag, " strobes"}, {5'b0, flush_dma_fifo, clr_dma_fifo, clr_scsi_fifo}, exp);
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (reg_rd && !done) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: read with no expected item, actual %02h expected none", reg_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({t, " rdata"}, reg_rdata, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        pins("R1", 1'b1, 1'b0);
        strobes("R1", 8'h00);
        rd(3'd0, 8'h80, "R1");
        rd(3'd2, 8'h00, "R1");

        // R2 / R4 / R11 enabled DMA condition
        wr(3'd1, 8'h7F);
        dma_evt = 7'h05; step(); dma_evt = '0;
        pins("R4 enabled", 1'b0, 1'b0);
        step();
        pins("R11 fatal seen", 1'b0, 1'b1);
        rd(3'd0, 8'h85, "R2");
        pins("R2 cleared", 1'b1, 1'b1);
        step();
        pins("R11 all clear", 1'b1, 1'b0);
        rd(3'd0, 8'h80, "R2");

        // R4 disabled DMA condition still fatal
        wr(3'd1, 8'h00);
        dma_evt = 7'h10; step(); dma_evt = '0;
        pins("R4 disabled", 1'b1, 1'b0);
        step();
        pins("R4 disabled halt", 1'b1, 1'b1);
        rd(3'd0, 8'h90, "R4");
        step();
        pins("R4 released", 1'b1, 1'b0);

        // R3 live FIFO-empty bit
        wr(3'd1, 8'h7F);
        dma_fifo_empty = 1'b0;
        pins("R3 empty low", 1'b1, 1'b0);
        rd(3'd0, 8'h00, "R3");
        dma_fifo_empty = 1'b1;
        rd(3'd0, 8'h80, "R3");
        rd(3'd0, 8'h80, "R3");
        pins("R3 no irq", 1'b1, 1'b0);

        // R5 SCSI not enabled
        wr(3'd3, 8'h00);
        scsi_evt = 8'h21; step(); scsi_evt = '0;
        pins("R5", 1'b1, 1'b0);
        step();
        pins("R5", 1'b1, 1'b0);
        rd(3'd2, 8'h21, "R5");
        rd(3'd2, 8'h00, "R5");

        // R6 enable written after latch
        scsi_evt = 8'h40; step(); scsi_evt = '0;
        pins("R6 before enable", 1'b1, 1'b0);
        wr(3'd3, 8'h40);
        pins("R6 enabled", 1'b0, 1'b0);
        step();
        pins("R6 halt", 1'b0, 1'b1);
        rd(3'd2, 8'h40, "R6");
        pins("R6 cleared", 1'b1, 1'b1);
        step();
        pins("R6 released", 1'b1, 1'b0);

        // R7 / R8 pin mask
        wr(3'd4, 8'h02);
        wr(3'd3, 8'h08);
        scsi_evt = 8'h08; step(); scsi_evt = '0;
        pins("R7 masked", 1'b1, 1'b0);
        step();
        pins("R7 halt kept", 1'b1, 1'b1);
        rd(3'd4, 8'h02, "R7");
        wr(3'd4, 8'h00);
        pins("R8 unmask", 1'b0, 1'b1);
        rd(3'd2, 8'h08, "R8");
        step(); step();
        pins("R8 released", 1'b1, 1'b0);

        // R9 event and clearing read in the same cycle
        wr(3'd3, 8'h00);
        scsi_evt = 8'h0C; step();
        scsi_evt = 8'h04;
        rd(3'd2, 8'h0C, "R9 scsi collide");
        scsi_evt = '0;
        rd(3'd2, 8'h04, "R9 scsi kept");
        rd(3'd2, 8'h00, "R9 scsi cleared");
        dma_evt = 7'h02;
        rd(3'd0, 8'h80, "R9 dma collide");
        dma_evt = '0;
        rd(3'd0, 8'h82, "R9 dma kept");
        rd(3'd0, 8'h80, "R9 dma cleared");
        step(); step();

        // R10 FIFO strobes
        wr(3'd5, 8'h06);
        strobes("R10 clear both", 8'h03);
        step();
        strobes("R10 self clear", 8'h00);
        wr(3'd5, 8'h08);
        strobes("R10 flush", 8'h04);
        step();
        strobes("R10 flush self clear", 8'h00);

        step();
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d items left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule